// File: doc/BRIEF.md
# SPI EEPROM Boot Read Engine

This block lets a boot sequencer fetch bytes from a serial EEPROM one at a time. The sequencer presents a byte address with a valid strobe while the engine is not busy. Some time later it receives the byte together with a single-cycle done pulse. On the serial side the engine acts as the bus master. It drives the serial clock, the data-out line and one active-low select, and it samples the data-in line. The clock idles low. Outgoing bits change on the falling clock edge. Incoming bits are captured on the rising edge. Every unit is one byte, most significant bit first.

The engine remembers the address of the byte it delivered last. When the next request asks for the following address, it leaves the select asserted and clocks eight more bits. The EEPROM's internal pointer then supplies the next location, so no command is resent. Any other request needs a new read command. If a stream is still open, the engine first raises the select for at least one full serial clock period. It then sends opcode 0x03, followed by the address in ADDR_BYTES bytes (3 by default, 2 for small parts), and then reads the data byte. The serial clock is the system clock divided by 2*HALF_DIV, which is 256 by default.

Top module: `spiboot_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, busy is 0 and done is 0.
- R2: The first request after reset always sends the full read command and address, even when its address is 1 (the address that would follow the reset value 0).
- R3: A request whose address is not the last delivered address plus one asserts spi_cs_n low and sends the byte 0x03. It then sends the address, most significant byte first, and then clocks in one data byte, which appears on rdata.
- R4: A request whose address equals the last delivered address plus one, modulo 2^(8*ADDR_BYTES), keeps spi_cs_n low and sends neither opcode nor address. It clocks in exactly one further byte, which is the content of the requested address.
- R5: With ADDR_BYTES set to 2, the address phase is two bytes long, and sequential detection wraps at 16 bits.
- R6: spi_mosi changes only on a falling spi_sck edge, or before the first rising edge of a byte. The EEPROM samples it on the rising edge, and data is shifted most significant bit first in both directions.
- R7: spi_sck is 0 whenever no byte is being shifted, and it is never high while spi_cs_n is 1.
- R8: Each high phase of spi_sck lasts exactly HALF_DIV system clocks.
- R9: When a non-sequential request arrives while a stream is open, spi_cs_n stays high for at least 2*HALF_DIV clocks before it falls again.
- R10: done is high for exactly one clock per request, and rdata changes only in a cycle where done is high.
- R11: busy rises in the clock after a request is accepted and stays high until done. A request presented while busy is ignored: it does not change the returned byte and starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe, accepted when busy is low |
| req_addr | input | 8*ADDR_BYTES | Byte address of the request |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when rdata holds the requested byte |
| rdata | output | 8 | Byte read, held until the next done |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM select |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The embedded properties check the following on every cycle:
- the serial timing rules: data-out moves only with a falling clock, the clock stays low outside a byte, and the clock is never high with the select released;
- the minimum select-high gap, using a counter;
- the single-cycle done pulse and the hold of rdata;
- that a sequential request leaves the select low.

Some behaviour cannot be seen from one cycle, and only the bench scenarios show it:
- that the right opcode and address bytes go out, and that streamed bytes come from the next EEPROM location;
- that the exact high-phase length is kept;
- that requests raised while busy are ignored;
- that the first request after reset, the address wrap, and the 2-byte variant are handled.

An EEPROM model decodes the serial traffic for these checks.

// File: rtl/spiboot_pkg.sv
package spiboot_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_CMD, ST_DATA} rd_state_t;
  localparam logic [7:0] READ_OPCODE = 8'h03;
endpackage

// File: rtl/spiboot_byte_xfer.sv
// One 8-bit mode-0 shift: the first bit is presented at start, later bits on
// falling edges, and input bits are captured on rising edges.
module spiboot_byte_xfer #(
  parameter int HALF_DIV = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          active_q, sck_q, done_q;
  logic [7:0]    tx_q, rx_q;
  logic          half_end;

  assign half_end = (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q <= 1'b1;
          tx_q     <= tx_byte;
          div_q    <= '0;
          bit_q    <= '0;
        end
      end else if (half_end) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso};
        end else begin
          sck_q <= 1'b0;
          tx_q  <= {tx_q[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[7];
  assign busy    = active_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_q[7]) && $past(active_q)) |-> $fell(sck_q))
    else $error("mosi moved without a falling sck"); // R6
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !sck_q)
    else $error("sck high outside a byte"); // R7
endmodule

// File: rtl/spiboot_addr_track.sv
// Holds the address delivered last and flags a request for the next one.
module spiboot_addr_track #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  input  logic [AW-1:0] probe_addr,
  output logic          seq_hit
);
  logic [AW-1:0] last_q;
  logic [AW-1:0] next_addr;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      valid_q <= 1'b0;
    end else if (commit) begin
      last_q  <= commit_addr;
      valid_q <= 1'b1;
    end
  end

  assign next_addr = last_q + AW'(1);
  assign seq_hit   = valid_q && (probe_addr == next_addr);
endmodule

// File: rtl/spiboot_reader.sv
module spiboot_reader #(
  parameter int HALF_DIV   = 128,
  parameter int ADDR_BYTES = 3,
  localparam int AW        = 8 * ADDR_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  output logic          spi_cs_n,
  input  logic          spi_miso
);
  import spiboot_pkg::*;

  localparam int IW = $clog2(ADDR_BYTES + 1);
  localparam int GW = $clog2(2 * HALF_DIV);
  localparam int CW = $clog2(2 * HALF_DIV + 1);

  rd_state_t     state_q;
  logic          cs_n_q, start_q, done_q;
  logic [7:0]    txb_q, rdata_q;
  logic [AW-1:0] cmd_sh_q, req_addr_q;
  logic [IW-1:0] idx_q;
  logic [GW-1:0] gap_q;
  logic          x_done, x_busy, x_sck, x_mosi;
  logic [7:0]    x_rx;
  logic          seq_hit, commit;

  assign commit = (state_q == ST_DATA) && x_done;

  spiboot_byte_xfer #(.HALF_DIV(HALF_DIV)) u_xfer (
    .clk(clk), .rst(rst), .start(start_q), .tx_byte(txb_q), .miso(spi_miso),
    .sck(x_sck), .mosi(x_mosi), .busy(x_busy), .done(x_done), .rx_byte(x_rx)
  );

  spiboot_addr_track #(.AW(AW)) u_track (
    .clk(clk), .rst(rst), .commit(commit), .commit_addr(req_addr_q),
    .probe_addr(req_addr), .seq_hit(seq_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cs_n_q     <= 1'b1;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      txb_q      <= '0;
      rdata_q    <= '0;
      cmd_sh_q   <= '0;
      req_addr_q <= '0;
      idx_q      <= '0;
      gap_q      <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          req_addr_q <= req_addr;
          cmd_sh_q   <= req_addr;
          idx_q      <= '0;
          if (seq_hit) begin
            start_q <= 1'b1;
            txb_q   <= 8'h00;
            state_q <= ST_DATA;
          end else if (!cs_n_q) begin
            cs_n_q  <= 1'b1;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cs_n_q  <= 1'b0;
            start_q <= 1'b1;
            txb_q   <= READ_OPCODE;
            state_q <= ST_CMD;
          end
        end
        ST_GAP: begin
          if (gap_q == GW'(2 * HALF_DIV - 1)) begin
            cs_n_q  <= 1'b0;
            start_q <= 1'b1;
            txb_q   <= READ_OPCODE;
            state_q <= ST_CMD;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        ST_CMD: if (x_done) begin
          start_q <= 1'b1;
          if (idx_q == IW'(ADDR_BYTES)) begin
            txb_q   <= 8'h00;
            state_q <= ST_DATA;
          end else begin
            txb_q    <= cmd_sh_q[AW-1 -: 8];
            cmd_sh_q <= cmd_sh_q << 8;
            idx_q    <= idx_q + IW'(1);
          end
        end
        ST_DATA: if (x_done) begin
          rdata_q <= x_rx;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign spi_sck  = x_sck;
  assign spi_mosi = x_mosi;
  assign spi_cs_n = cs_n_q;

  // Checker state: select-high run length, and whether the select was ever low.
  logic [CW-1:0] cs_hi_cnt_q;
  logic          was_low_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi_cnt_q <= '0;
      was_low_q   <= 1'b0;
    end else begin
      if (!cs_n_q) begin
        cs_hi_cnt_q <= '0;
        was_low_q   <= 1'b1;
      end else if (cs_hi_cnt_q != CW'(2 * HALF_DIV)) begin
        cs_hi_cnt_q <= cs_hi_cnt_q + CW'(1);
      end
    end
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_q) && was_low_q) |-> (cs_hi_cnt_q >= CW'(2 * HALF_DIV)))
    else $error("select gap too short"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q)
    else $error("done longer than one cycle"); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata_q) |-> done_q)
    else $error("rdata moved without done"); // R10
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    x_sck |-> !cs_n_q)
    else $error("sck high with select released"); // R7
  AST_SEQ_KEEPS_CS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && req_valid && seq_hit) |=> !cs_n_q)
    else $error("sequential read dropped select"); // R4
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && req_valid) |=> busy)
    else $error("accepted request not busy"); // R11
  AST_ENGINE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !x_busy)
    else $error("shifter active while idle"); // R11
endmodule

// File: tb/tb_spiboot_reader.sv
`timescale 1ns/1ps

package tb_spiboot_pkg;
  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ {a[23:20], a[3:0]} ^ 8'h5A;
  endfunction
endpackage

module tb_eeprom_model #(
  parameter int AB = 3
) (
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output int          cmd_count,
  output logic [7:0]  op,
  output logic [23:0] addr_cap
);
  import tb_spiboot_pkg::*;
  localparam int HDR = 8 * (AB + 1);
  int          bits;
  int          k;
  logic [31:0] sh;
  logic [23:0] a;
  logic [7:0]  b;

  initial begin
    bits = 0; miso = 1'b0; cmd_count = 0; op = '0; addr_cap = '0; sh = '0;
  end

  always @(negedge cs_n) begin
    bits = 0;
    cmd_count++;
  end

  always @(posedge sck) if (cs_n === 1'b0) begin
    if (bits < HDR) begin
      sh = {sh[30:0], mosi};
      if (bits == 7) op = sh[7:0];
      if (bits == HDR - 1) addr_cap = (AB == 3) ? sh[23:0] : {8'h00, sh[15:0]};
    end
    bits++;
  end

  always @(negedge sck) if (cs_n === 1'b0 && bits >= HDR) begin
    k = bits - HDR;
    a = addr_cap + 24'(k / 8);
    if (AB == 2) a[23:16] = 8'h00;
    b = mem_byte(a);
    miso = b[7 - (k % 8)];
  end
endmodule

module tb_spiboot_reader;
  import tb_spiboot_pkg::*;
  localparam int HD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rv = 1'b0, rv2 = 1'b0;
  logic [23:0] ra = '0;
  logic [15:0] ra2 = '0;
  logic        busy, done, sck, mosi, cs_n, miso;
  logic        busy2, done2, sck2, mosi2, cs2, miso2;
  logic [7:0]  rdata, rdata2;
  int          cmd1, cmd2;
  logic [7:0]  op1, op2;
  logic [23:0] ad1, ad2;

  int n_cmp = 0, n_bad = 0;
  int hi_run = 0, sck_err = 0, cs_run = 0, last_gap = 0, r7_err = 0;
  bit          lv = 0;
  logic [23:0] lv_addr = '0;

  always #2.5 clk = ~clk;

  spiboot_reader #(.HALF_DIV(HD), .ADDR_BYTES(3)) dut (
    .clk(clk), .rst(rst), .req_valid(rv), .req_addr(ra), .busy(busy),
    .done(done), .rdata(rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_cs_n(cs_n), .spi_miso(miso));
  tb_eeprom_model #(.AB(3)) m1 (.cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .cmd_count(cmd1), .op(op1), .addr_cap(ad1));

  spiboot_reader #(.HALF_DIV(HD), .ADDR_BYTES(2)) dut2 (
    .clk(clk), .rst(rst), .req_valid(rv2), .req_addr(ra2), .busy(busy2),
    .done(done2), .rdata(rdata2), .spi_sck(sck2), .spi_mosi(mosi2),
    .spi_cs_n(cs2), .spi_miso(miso2));
  tb_eeprom_model #(.AB(2)) m2 (.cs_n(cs2), .sck(sck2), .mosi(mosi2), .miso(miso2),
    .cmd_count(cmd2), .op(op2), .addr_cap(ad2));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Serial-side monitors, sampled away from the active edge.
  always @(negedge clk) if (!rst) begin
    if (sck) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run != HD) sck_err++;
      hi_run = 0;
    end
    if (sck && cs_n) r7_err++;
    if (!busy && sck) r7_err++;
    if (cs_n) cs_run++;
    else if (cs_run > 0) begin
      last_gap = cs_run;
      cs_run = 0;
    end
  end

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  task automatic rd(input logic [23:0] a, input bit bogus);
    bit exp_seq;
    int c0, waitc;
    logic [7:0] exp_d;
    exp_seq = lv && (a == 24'(lv_addr + 24'd1));
    exp_d = mem_byte(a);
    @(negedge clk);
    while (busy) @(negedge clk);
    c0 = cmd1;
    rv = 1'b1; ra = a;
    @(negedge clk);
    rv = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    if (bogus) begin
      repeat (3) @(negedge clk);
      rv = 1'b1; ra = a ^ 24'h5A5A5A;
      @(negedge clk);
      rv = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    check(rdata == exp_d, exp_seq ? "R4 streamed byte" : "R3 data byte", rdata, exp_d);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    if (exp_seq) begin
      check(cmd1 == c0, "R4 no new command", cmd1, c0);
    end else begin
      check(cmd1 == c0 + 1, lv ? "R3 new command" : "R2 first command", cmd1, c0 + 1);
      check(op1 == 8'h03, "R3/R6 opcode", op1, 8'h03);
      check(ad1 == a, "R3/R6 address", ad1, a);
      if (lv) check(last_gap >= 2 * HD, "R9 select gap", last_gap, 2 * HD);
    end
    repeat (5) @(negedge clk);
    check(rdata == exp_d && !busy, "R10/R11 hold and ignore", {busy, rdata}, {1'b0, exp_d});
    if (bogus) check(cmd1 == (exp_seq ? c0 : c0 + 1), "R11 busy request ignored", cmd1, c0);
    lv = 1;
    lv_addr = a;
  endtask

  task automatic rd2(input logic [15:0] a, input bit exp_seq);
    int c0;
    logic [7:0] exp_d;
    exp_d = mem_byte({8'h00, a});
    @(negedge clk);
    while (busy2) @(negedge clk);
    c0 = cmd2;
    rv2 = 1'b1; ra2 = a;
    @(negedge clk);
    rv2 = 1'b0;
    while (!done2) @(negedge clk);
    check(rdata2 == exp_d, "R5 data byte", rdata2, exp_d);
    check(cmd2 == (exp_seq ? c0 : c0 + 1), "R5 command count", cmd2, exp_seq ? c0 : c0 + 1);
    if (!exp_seq) check(ad2 == {8'h00, a} && op2 == 8'h03, "R5 2-byte header", ad2, a);
  endtask

  initial begin
    logic [23:0] na;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
    check(sck == 1'b0, "R1 sck reset", sck, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done reset", {busy, done}, 0);

    rd(24'h000001, 1'b0);   // R2: looks sequential to reset value, must not be
    rd(24'h000002, 1'b0);
    rd(24'h000003, 1'b1);   // R11: extra request while busy
    rd(24'h000100, 1'b0);   // R3, R9
    rd(24'hFFFFFF, 1'b0);
    rd(24'h000000, 1'b0);   // R4: wrap is sequential
    for (int i = 0; i < 24; i++) begin
      if (($urandom % 2) == 1) na = 24'(lv_addr + 24'd1);
      else na = 24'($urandom);
      rd(na, (i % 7) == 3);
    end

    rd2(16'h1234, 1'b0);
    rd2(16'h1235, 1'b1);
    rd2(16'hFFFF, 1'b0);
    rd2(16'h0000, 1'b1);    // R5: 16-bit wrap

    check(sck_err == 0, "R8 high phase length", sck_err, 0);
    check(r7_err == 0, "R7 sck idle low", r7_err, 0);
    summary();
  end
endmodule